// File: doc/BRIEF.md
# Hysteretic Burst-Mode Drive Gate

This block decides, cycle by cycle, whether the half-bridge switches of a resonant converter may switch. Three inputs come in from outside: a flag raised by the comparator that watches the output voltage reach its lower limit, a flag raised when the voltage reaches its upper limit, and a level that reads 1 when the load has dropped to zero and 0 at full load. An enable that is held between events is built from these inputs. At full load the switches run without a break. At zero load the enable behaves like a set/reset element between the two voltage limits. The lower-limit condition outranks the load override, and a fault case outranks everything else.

All inputs are asynchronous to the block clock and go through two-flop synchronizers. The free-running switching clock also arrives as an input. The block turns it into two complementary gate drives and inserts a dead time of a parameterised number of block-clock cycles, during which both drives are low. The enable is sampled only at each phase boundary of the switching clock, so a gate pulse that has started always runs to its full length.

Top module: `burst_drive_gate`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `drive_en_o`, `gate_hi_o` and `gate_lo_o` are all 0.
- R2: When the lower-limit flag is 1 and the upper-limit flag is 0, the enable becomes 1, whatever the load level is.
- R3: At zero load (load level 1), when the upper-limit flag is 1 and the lower-limit flag is 0, the enable becomes 0.
- R4: When both comparator flags are 1 together, the enable is 0. This has the highest priority.
- R5: At full load (load level 0) with no fault, the enable is 1. This includes the cycle in which the load returns from 1 to 0, and an upper-limit flag is ignored.
- R6: A rising edge of the load level (full to zero load) clears the enable unless the lower-limit flag is 1.
- R7: At zero load with both comparator flags 0 and no load edge, the enable keeps its previous value.
- R8: An input change first shows on `drive_en_o` after the third rising clock edge that follows it (two synchronizer stages plus the enable register).
- R9: `gate_hi_o` pulses during the high phase of the switching clock and `gate_lo_o` during the low phase. Each pulse lasts one phase minus DEAD_CYC cycles, and the two drives are never high together.
- R10: Between the end of one gate pulse and the start of the next, both drives stay low for exactly DEAD_CYC cycles.
- R11: The enable is sampled only at phase boundaries. A pulse in progress is not shortened when the enable drops, and both drives stay low for every phase that begins with the enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_lim_i | input | 1 | Output voltage at or below the lower limit (asynchronous) |
| hi_lim_i | input | 1 | Output voltage at or above the upper limit (asynchronous) |
| load_zero_i | input | 1 | 1 = zero load, 0 = full load (asynchronous) |
| sw_clk_i | input | 1 | Free-running switching clock (asynchronous level) |
| drive_en_o | output | 1 | Held drive enable, 1 = switches allowed on |
| gate_hi_o | output | 1 | Gate drive for the upper switch |
| gate_lo_o | output | 1 | Gate drive for the lower switch |

## Verification
An input change reaches the enable after exactly three rising edges. The bench changes inputs on falling edges and checks the enable two nanoseconds after rising edges: once after the second edge, where it must not have moved yet, and once after the third, where it must. The enable sweep walks through every ordered pair of the eight comparator and load combinations. Each combination is held for four cycles, which covers the one-cycle edge evaluation and the settled hold. A reference function in the bench predicts the result from the stated priority order. On the gate side, the bench drives a switching clock with a phase of eight cycles and measures run lengths at the outputs: each pulse must last six cycles and each gap between pulses two. The enable is also dropped in the middle of a pulse, and the bench confirms that this pulse still completes and that both drives then stay low.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;

    // Which rule decided the next enable value, in priority order.
    typedef enum logic [2:0] {
        ACT_HOLD      = 3'd0,
        ACT_FAULT     = 3'd1,
        ACT_LOW_SET   = 3'd2,
        ACT_FULL_ON   = 3'd3,
        ACT_LOAD_OFF  = 3'd4,
        ACT_HIGH_OFF  = 3'd5
    } arb_act_t;

    typedef struct packed {
        logic en;
        logic ld_p;
    } arb_state_t;

endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/enable_arbiter.sv
module enable_arbiter
    import burst_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lo_s,
    input  logic hi_s,
    input  logic ld_s,
    output logic en_o,
    output logic ld_prev_o
);
    arb_state_t st_d;
    arb_state_t st_q;
    arb_act_t   act;
    logic       ld_rise;

    always_comb begin
        ld_rise = ld_s & ~st_q.ld_p;

        if (lo_s && hi_s) begin
            act = ACT_FAULT;
        end else if (lo_s) begin
            act = ACT_LOW_SET;
        end else if (!ld_s) begin
            act = ACT_FULL_ON;
        end else if (ld_rise) begin
            act = ACT_LOAD_OFF;
        end else if (hi_s) begin
            act = ACT_HIGH_OFF;
        end else begin
            act = ACT_HOLD;
        end

        st_d      = st_q;
        st_d.ld_p = ld_s;
        unique case (act)
            ACT_FAULT:    st_d.en = 1'b0;
            ACT_LOW_SET:  st_d.en = 1'b1;
            ACT_FULL_ON:  st_d.en = 1'b1;
            ACT_LOAD_OFF: st_d.en = 1'b0;
            ACT_HIGH_OFF: st_d.en = 1'b0;
            default:      st_d.en = st_q.en;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o      = st_q.en;
    assign ld_prev_o = st_q.ld_p;
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sw_s,
    output logic gate_hi_o,
    output logic gate_lo_o
);
    localparam int DCNT_W = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic              run;
        logic              phase;
        logic              sw_p;
        logic [DCNT_W-1:0] dcnt;
    } seq_t;

    seq_t st_d;
    seq_t st_q;
    logic boundary;
    logic settled;

    always_comb begin
        boundary  = sw_s ^ st_q.sw_p;
        st_d      = st_q;
        st_d.sw_p = sw_s;
        if (boundary) begin
            st_d.run   = en_i;
            st_d.phase = sw_s;
            st_d.dcnt  = DCNT_W'(DEAD_CYC);
        end else if (st_q.dcnt != '0) begin
            st_d.dcnt = st_q.dcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign settled   = st_q.run && (st_q.dcnt == '0);
    assign gate_hi_o = settled &&  st_q.phase;
    assign gate_lo_o = settled && !st_q.phase;
endmodule

// File: rtl/burst_drive_gate.sv
module burst_drive_gate #(
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_lim_i,
    input  logic hi_lim_i,
    input  logic load_zero_i,
    input  logic sw_clk_i,
    output logic drive_en_o,
    output logic gate_hi_o,
    output logic gate_lo_o
);
    localparam int NUM_IN = 4;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] syn_in;
    logic lo_sync;
    logic hi_sync;
    logic ld_sync;
    logic sw_sync;
    logic ld_prev;
    logic en;

    assign raw_in = {sw_clk_i, load_zero_i, hi_lim_i, lo_lim_i};

    sync_pipe #(.W(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign lo_sync = syn_in[0];
    assign hi_sync = syn_in[1];
    assign ld_sync = syn_in[2];
    assign sw_sync = syn_in[3];

    enable_arbiter arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_s      (lo_sync),
        .hi_s      (hi_sync),
        .ld_s      (ld_sync),
        .en_o      (en),
        .ld_prev_o (ld_prev)
    );

    gate_sequencer #(.DEAD_CYC(DEAD_CYC)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .sw_s      (sw_sync),
        .gate_hi_o (gate_hi_o),
        .gate_lo_o (gate_lo_o)
    );

    assign drive_en_o = en;
endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic lo_s,
    input logic hi_s,
    input logic ld_s,
    input logic ld_p,
    input logic en,
    input logic gh,
    input logic gl
);
    // R1: outputs cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!en && !gh && !gl);
        end
    end

    a_r4_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_s && hi_s) |=> !en);

    a_r2_lower_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_s && !hi_s) |=> en);

    a_r5_full_load_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_s && !(lo_s && hi_s)) |=> en);

    a_r6_load_rise_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && !ld_p && !lo_s) |=> !en);

    a_r3_upper_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && hi_s && !lo_s) |=> !en);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && ld_p && !lo_s && !hi_s) |=> $stable(en));

    a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(gh && gl));

    a_r10_dead_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gh) |-> !gl);

    a_r10_dead_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gl) |-> !gh);
endmodule

bind burst_drive_gate burst_gate_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lo_s  (lo_sync),
    .hi_s  (hi_sync),
    .ld_s  (ld_sync),
    .ld_p  (ld_prev),
    .en    (drive_en_o),
    .gh    (gate_hi_o),
    .gl    (gate_lo_o)
);

// File: tb/burst_drive_gate_tb_top.sv
`timescale 1ns/1ps
module burst_drive_gate_tb_top;
    localparam int DEAD  = 2;
    localparam int HALF  = 8;
    localparam int PULSE = HALF - DEAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_i = 1'b0;
    logic hi_i = 1'b1;
    logic ld_i = 1'b1;
    logic sw_i = 1'b0;
    logic en_o, gh_o, gl_o;

    int checks = 0;
    int fails  = 0;
    int sw_cnt = 0;
    int pulse_checks = 0;
    logic mon_on = 1'b0;
    logic exp_en;
    logic [2:0] pv;

    always #10 clk = ~clk;

    burst_drive_gate #(.SYNC_STAGES(2), .DEAD_CYC(DEAD)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_lim_i    (lo_i),
        .hi_lim_i    (hi_i),
        .load_zero_i (ld_i),
        .sw_clk_i    (sw_i),
        .drive_en_o  (en_o),
        .gate_hi_o   (gh_o),
        .gate_lo_o   (gl_o)
    );

    // free-running switching clock, HALF block cycles per phase
    always @(negedge clk) begin
        if (sw_cnt == HALF - 1) begin
            sw_cnt <= 0;
            sw_i   <= ~sw_i;
        end else begin
            sw_cnt <= sw_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference enable rule; v[0]=lower flag, v[1]=upper flag, v[2]=load zero
    function automatic logic ref_en(input logic [2:0] v, input logic rise, input logic e);
        if (v[0] && v[1])  return 1'b0;
        else if (v[0])     return 1'b1;
        else if (!v[2])    return 1'b1;
        else if (rise)     return 1'b0;
        else if (v[1])     return 1'b0;
        else               return e;
    endfunction

    function automatic string ref_tag(input logic [2:0] v, input logic rise);
        if (v[0] && v[1])  return "R4";
        else if (v[0])     return "R2";
        else if (!v[2])    return "R5";
        else if (rise)     return "R6";
        else if (v[1])     return "R3";
        else               return "R7";
    endfunction

    task automatic step(input logic [2:0] v);
        logic rise;
        @(negedge clk);
        lo_i = v[0];
        hi_i = v[1];
        ld_i = v[2];
        repeat (4) @(posedge clk);
        #2;
        rise   = v[2] & ~pv[2];
        exp_en = ref_en(v, rise, exp_en);
        exp_en = ref_en(v, 1'b0, exp_en);
        check(ref_tag(v, rise), int'(en_o), int'(exp_en));
        pv = v;
    endtask

    // gate run-length monitor: kind 0 none, 1 high, 2 low
    int cur_kind = 0;
    int run_len = 0;
    logic first_run = 1'b1;
    logic had_pulse = 1'b0;
    always @(posedge clk) begin
        int k;
        #2;
        k = gh_o ? 1 : (gl_o ? 2 : 0);
        if (gh_o && gl_o) check("R9 both high", 1, 0);
        if (!mon_on) begin
            cur_kind  = k;
            run_len   = 0;
            first_run = 1'b1;
            had_pulse = 1'b0;
        end else if (k == cur_kind) begin
            run_len++;
        end else begin
            if (!first_run) begin
                if (cur_kind != 0) begin
                    check("R9 R11 pulse length", run_len, PULSE);
                    pulse_checks++;
                end else if (had_pulse) begin
                    check("R10 dead gap", run_len, DEAD);
                end
            end
            if (cur_kind != 0) had_pulse = 1'b1;
            first_run = 1'b0;
            cur_kind  = k;
            run_len   = 1;
        end
    end

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 en in reset", int'(en_o), 0);
        check("R1 gates in reset", int'(gh_o | gl_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 en after release", int'(en_o), 0);
        repeat (8) @(posedge clk);
        #2;
        // inputs (lo=0,hi=1,ld=1) held since reset: rise then upper flag -> 0
        exp_en = 1'b0;
        pv     = 3'b110;
        check("R3 settled after reset", int'(en_o), 0);

        // R8: latency of a lower-limit set
        @(negedge clk);
        lo_i = 1'b1;
        hi_i = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R8 not yet after two edges", int'(en_o), 0);
        @(posedge clk);
        #2;
        check("R8 set after third edge", int'(en_o), 1);
        // R8: latency of an upper-limit clear
        @(negedge clk);
        lo_i = 1'b0;
        hi_i = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check("R8 still set after two edges", int'(en_o), 1);
        @(posedge clk);
        #2;
        check("R8 cleared after third edge", int'(en_o), 0);
        repeat (4) @(posedge clk);
        pv = 3'b110;
        exp_en = 1'b0;

        // exhaustive ordered pairs of input combinations
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                step(3'(a));
                step(3'(b));
            end
        end

        // gate generation at full load
        step(3'b000);
        repeat (4 * HALF) @(posedge clk);
        @(negedge clk);
        mon_on = 1'b1;
        repeat (8 * HALF + 3) @(posedge clk);
        // R11: drop the enable mid-phase; the running pulse must complete
        @(negedge clk);
        ld_i = 1'b1;
        hi_i = 1'b1;
        repeat (4 * HALF) @(posedge clk);
        @(negedge clk);
        mon_on = 1'b0;
        check("R9 pulses measured", int'(pulse_checks >= 6), 1);
        begin
            int seen = 0;
            for (int i = 0; i < 3 * HALF; i++) begin
                @(posedge clk);
                #2;
                if (gh_o || gl_o) seen++;
            end
            check("R11 gates low while disabled", seen, 0);
        end
        check("R3 enable off at zero load", int'(en_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule